// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the serial slave that gives a host read and write access to a bank of 16-bit configuration registers over a two-line bus with a clock line and a data line. Both bus lines are oversampled by the local master clock. Each line passes through a two-flop synchronizer and a stability filter before any edge is used, so every bus timing rule is enforced as a count of master-clock cycles. START and STOP conditions are found on the filtered lines.

A transfer opens with a device byte: seven address bits and then a direction bit. A write names an 8-bit register pointer and then sends one or more 16-bit words. Each word travels as two bytes, high byte first, and the slave acknowledges every byte. The block raises a one-cycle write strobe with the pointer and the word only once the second byte has been acknowledged, and then steps the pointer. A read, usually reached through a repeated START, raises a one-cycle request. The register bank answers it in the same cycle, and the slave shifts the word out MSB first. A master acknowledge after the low byte fetches the next register. A missing acknowledge makes the slave let go of the data line and stay quiet until the next START or STOP.

The data line is open drain. The block only reports when it wants the line pulled low, and the pad or the board combines that with the pull-up.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, `sda_oe`, `wr_en` and `rd_req` are all 0.
- R2: When the device byte's upper seven bits equal `DEV_ADDR`, the slave pulls the data line low during the ninth clock. On any other address it never pulls the line low and issues no strobe or request until the next START.
- R3: A write transfer (START, device byte with direction bit 0, pointer byte, high byte, low byte) gives exactly one `wr_en` pulse of one cycle. That pulse carries `wr_addr` equal to the pointer and `wr_data` equal to {high, low}, and it comes only after the low byte's acknowledge, never before.
- R4: Every byte that reaches a selected slave in a write is acknowledged by a low data line during its ninth clock. The slave's drive changes only while the clock line is low.
- R5: A STOP after only the high byte of a word produces no `wr_en`.
- R6: A repeated START followed by the device byte with direction bit 1 raises `rd_req` for one cycle with `rd_addr` equal to the pointer. The slave then returns `rd_data[15:8]` and then `rd_data[7:0]`, MSB first. `rd_data` is taken in the same cycle as `rd_req`.
- R7: After each completed word the pointer steps by one. Further words written in the same transfer go to the next addresses, and a master acknowledge after a read low byte raises `rd_req` for the next address.
- R8: When the master does not acknowledge a read byte, the slave releases the data line and does not drive it for any further clocks until a START or STOP.
- R9: A clock-line pulse shorter than `FILT_LEN` master cycles is ignored and does not shift a bit.
- R10: With no START after a STOP, clocked data, even a matching device byte, gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 16 | Word to write |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 8 | Register address of the read |
| rd_data | input | 16 | Read word, valid in the cycle of `rd_req` |

## Verification
The hardest state to reach from the ports is the byte boundary inside a read burst. There the slave hands the line to the master for the acknowledge, steps the pointer, fetches a new word and drives its first bit, all within one low phase of the clock. The stimulus reaches it with a pointer write, a repeated START and a four-byte read that acknowledges three bytes and refuses the last. It checks the addresses of both requests and every returned byte, then clocks nine extra bits to show the line stays released. A clock glitch shorter than the filter is injected in the middle of a data byte, and the word written afterwards must be intact.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD
  } tws_state_t;
endpackage

// File: rtl/tws_filter.sv
module tws_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2, q, q_n;
  logic [CW-1:0] cnt, cnt_n;

  // A new level is accepted only after FILT_LEN consecutive disagreeing samples
  always_comb begin
    q_n   = q;
    cnt_n = '0;
    if (s2 != q) begin
      if (cnt == CW'(FILT_LEN - 1)) q_n = s2;
      else                          cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      q   <= 1'b1;
      cnt <= '0;
    end else begin
      s1  <= raw_i;
      s2  <= s1;
      q   <= q_n;
      cnt <= cnt_n;
    end
  end

  assign filt_o = q;
endmodule

// File: rtl/tws_cond.sv
module tws_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_s,
  input  logic [WORD_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_req,
  output logic [BYTE_W-1:0] rd_addr
);
  localparam logic [BCNT_W-1:0] FULL = BCNT_W'(BYTE_W);

  tws_state_t        st, st_n;
  logic [BCNT_W-1:0] bcnt, bcnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n, hib, hib_n, lob, lob_n, ptr, ptr_n;
  logic [BYTE_W-1:0] wa_n;
  logic [WORD_W-1:0] wd_n;
  logic              ackph, ackph_n, oe_n, idx, idx_n, mack, mack_n;
  logic              wr_n, rq_n;

  always_comb begin
    st_n    = st;
    bcnt_n  = bcnt;
    shreg_n = shreg;
    hib_n   = hib;
    lob_n   = lob;
    ptr_n   = ptr;
    wa_n    = wr_addr;
    wd_n    = wr_data;
    ackph_n = ackph;
    oe_n    = sda_oe;
    idx_n   = idx;
    mack_n  = mack;
    wr_n    = 1'b0;
    rq_n    = 1'b0;
    // Word fetched in the request cycle; first bit goes out at once
    if (rd_req) begin
      shreg_n = rd_data[WORD_W-1:BYTE_W];
      lob_n   = rd_data[BYTE_W-1:0];
      oe_n    = ~rd_data[WORD_W-1];
    end
    if (start_c) begin
      st_n    = ST_DEV;
      bcnt_n  = '0;
      ackph_n = 1'b0;
      oe_n    = 1'b0;
      idx_n   = 1'b0;
    end else if (stop_c) begin
      st_n    = ST_IDLE;
      ackph_n = 1'b0;
      oe_n    = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_REG, ST_WR: begin
          if (!ackph) begin
            if (scl_rise && bcnt != FULL) begin
              shreg_n = {shreg[BYTE_W-2:0], sda_s};
              bcnt_n  = bcnt + 1'b1;
            end
            if (scl_fall && bcnt == FULL) begin
              if (st == ST_DEV && shreg[BYTE_W-1:1] != DEV_ADDR) begin
                st_n = ST_IDLE;
              end else begin
                ackph_n = 1'b1;
                oe_n    = 1'b1;
              end
            end
          end else if (scl_fall) begin
            ackph_n = 1'b0;
            oe_n    = 1'b0;
            bcnt_n  = '0;
            case (st)
              ST_DEV: begin
                if (shreg[0]) begin
                  st_n  = ST_RD;
                  rq_n  = 1'b1;
                  idx_n = 1'b0;
                end else begin
                  st_n = ST_REG;
                end
              end
              ST_REG: begin
                ptr_n = shreg;
                st_n  = ST_WR;
                idx_n = 1'b0;
              end
              default: begin
                if (!idx) begin
                  hib_n = shreg;
                  idx_n = 1'b1;
                end else begin
                  wr_n  = 1'b1;
                  wa_n  = ptr;
                  wd_n  = {hib, shreg};
                  ptr_n = ptr + 1'b1;
                  idx_n = 1'b0;
                end
              end
            endcase
          end
        end
        ST_RD: begin
          if (!ackph) begin
            if (scl_rise && bcnt != FULL) bcnt_n = bcnt + 1'b1;
            if (scl_fall) begin
              if (bcnt == FULL) begin
                ackph_n = 1'b1;
                oe_n    = 1'b0;
              end else begin
                shreg_n = {shreg[BYTE_W-2:0], 1'b0};
                oe_n    = ~shreg[BYTE_W-2];
              end
            end
          end else begin
            if (scl_rise) mack_n = ~sda_s;
            if (scl_fall) begin
              ackph_n = 1'b0;
              bcnt_n  = '0;
              if (!mack) begin
                st_n = ST_IDLE;
              end else if (!idx) begin
                idx_n   = 1'b1;
                shreg_n = lob;
                oe_n    = ~lob[BYTE_W-1];
              end else begin
                idx_n = 1'b0;
                ptr_n = ptr + 1'b1;
                rq_n  = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      hib     <= '0;
      lob     <= '0;
      ptr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      ackph   <= 1'b0;
      sda_oe  <= 1'b0;
      idx     <= 1'b0;
      mack    <= 1'b0;
      wr_en   <= 1'b0;
      rd_req  <= 1'b0;
    end else begin
      st      <= st_n;
      bcnt    <= bcnt_n;
      shreg   <= shreg_n;
      hib     <= hib_n;
      lob     <= lob_n;
      ptr     <= ptr_n;
      wr_addr <= wa_n;
      wr_data <= wd_n;
      ackph   <= ackph_n;
      sda_oe  <= oe_n;
      idx     <= idx_n;
      mack    <= mack_n;
      wr_en   <= wr_n;
      rd_req  <= rq_n;
    end
  end

  assign rd_addr = ptr;
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_req,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    tws_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[i]), .filt_o(filt[i])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  tws_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  tws_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(sda_f),
    .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/tws_reg_slave_chk.sv
module tws_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic scl_fall,
  input logic sda_oe,
  input logic wr_en,
  input logic rd_req
);
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_wr_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall));

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_rd_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(scl_fall));

  p_wr_rd_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));

  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));
endmodule

bind tws_reg_slave tws_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_fall(scl_fall),
  .sda_oe(sda_oe), .wr_en(wr_en), .rd_req(rd_req)
);

// File: tb/tb_tws_reg_slave.sv
module tb_tws_reg_slave;
  localparam logic [6:0] DEV = 7'h48;
  localparam int Q = 16;

  logic        clk, rst_n, scl_m, sda_m;
  logic        sda_oe, wr_en, rd_req;
  logic [7:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk, n_bad, wr_cnt, rd_cnt;
  logic [7:0]  wa_log [16];
  logic [15:0] wd_log [16];
  logic [7:0]  last_ra;
  bit done;

  assign rd_data = {rd_addr ^ 8'hA5, rd_addr};

  tws_reg_slave #(.DEV_ADDR(DEV), .FILT_LEN(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    wr_cnt = 0;
    rd_cnt = 0;
    last_ra = '0;
    forever begin
      @(negedge clk);
      if (wr_en) begin
        wa_log[wr_cnt % 16] = wr_addr;
        wd_log[wr_cnt % 16] = wr_data;
        wr_cnt++;
      end
      if (rd_req) begin
        last_ra = rd_addr;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_x(input logic b, input bit glitch, output logic smp);
    sda_m = b;
    if (glitch) begin
      wq(4); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q - 6);
    end else wq(Q);
    scl_m = 1'b1; wq(Q);
    smp = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input int gbit, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(v[i], (i == gbit), s);
    bit_x(1'b1, 1'b0, s);
    ack = (s == 1'b0);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, 1'b0, s);
      v[i] = s;
    end
    bit_x(~mack, 1'b0, s);
  endtask

  task automatic t_reset;
    chk("R1 outputs idle", {29'd0, sda_oe, wr_en, rd_req}, 32'd0);
  endtask

  task automatic t_write;
    bit a; int b0;
    b0 = wr_cnt;
    bus_start;
    wr_byte({DEV, 1'b0}, -1, a); chk("R2 address ack", a, 1);
    wr_byte(8'h21, -1, a);       chk("R4 pointer ack", a, 1);
    wr_byte(8'hC3, -1, a);       chk("R4 high ack", a, 1);
    chk("R3 no strobe before low byte", wr_cnt - b0, 0);
    wr_byte(8'h5A, -1, a);       chk("R4 low ack", a, 1);
    bus_stop;
    chk("R3 one strobe", wr_cnt - b0, 1);
    chk("R3 address", wa_log[b0 % 16], 8'h21);
    chk("R3 data", wd_log[b0 % 16], 16'hC35A);
  endtask

  task automatic t_partial;
    bit a; int b0;
    b0 = wr_cnt;
    bus_start;
    wr_byte({DEV, 1'b0}, -1, a);
    wr_byte(8'h30, -1, a);
    wr_byte(8'h11, -1, a);
    bus_stop;
    chk("R5 no strobe on half word", wr_cnt - b0, 0);
  endtask

  task automatic t_burst;
    bit a; int b0;
    b0 = wr_cnt;
    bus_start;
    wr_byte({DEV, 1'b0}, -1, a);
    wr_byte(8'h7F, -1, a);
    wr_byte(8'h12, -1, a); wr_byte(8'h34, -1, a);
    wr_byte(8'hAB, -1, a); wr_byte(8'hCD, -1, a);
    bus_stop;
    chk("R7 two strobes", wr_cnt - b0, 2);
    chk("R7 first address", wa_log[b0 % 16], 8'h7F);
    chk("R7 second address", wa_log[(b0 + 1) % 16], 8'h80);
    chk("R7 second data", wd_log[(b0 + 1) % 16], 16'hABCD);
  endtask

  task automatic t_read;
    bit a; int b0, lows; logic [7:0] v; logic s;
    bus_start;
    wr_byte({DEV, 1'b0}, -1, a);
    wr_byte(8'h10, -1, a);
    b0 = rd_cnt;
    bus_start;
    wr_byte({DEV, 1'b1}, -1, a); chk("R2 read address ack", a, 1);
    chk("R6 request address", last_ra, 8'h10);
    rd_byte(1'b1, v); chk("R6 high byte", v, 8'hB5);
    rd_byte(1'b1, v); chk("R6 low byte", v, 8'h10);
    rd_byte(1'b1, v); chk("R7 next high byte", v, 8'hB4);
    chk("R7 next request address", last_ra, 8'h11);
    rd_byte(1'b0, v); chk("R7 next low byte", v, 8'h11);
    chk("R7 request count", rd_cnt - b0, 2);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, 1'b0, s);
      if (s == 1'b0) lows++;
    end
    chk("R8 released after no ack", lows, 0);
    chk("R8 no further request", rd_cnt - b0, 2);
    bus_stop;
  endtask

  task automatic t_mismatch;
    bit a; int b0, acks;
    b0 = wr_cnt;
    acks = 0;
    bus_start;
    wr_byte({DEV ^ 7'h01, 1'b0}, -1, a); chk("R2 no ack other address", a, 0);
    wr_byte(8'h40, -1, a); if (a) acks++;
    wr_byte(8'h99, -1, a); if (a) acks++;
    wr_byte(8'h77, -1, a); if (a) acks++;
    bus_stop;
    chk("R2 silent on bytes", acks, 0);
    chk("R2 no strobe", wr_cnt - b0, 0);
  endtask

  task automatic t_nostart;
    bit a; int b0;
    b0 = wr_cnt;
    scl_m = 1'b0; wq(Q);
    wr_byte({DEV, 1'b0}, -1, a); chk("R10 no ack without start", a, 0);
    wr_byte(8'h01, -1, a);
    wr_byte(8'h02, -1, a);
    wr_byte(8'h03, -1, a);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    chk("R10 no strobe", wr_cnt - b0, 0);
  endtask

  task automatic t_glitch;
    bit a; int b0;
    b0 = wr_cnt;
    bus_start;
    wr_byte({DEV, 1'b0}, -1, a);
    wr_byte(8'h05, -1, a);
    wr_byte(8'h96, 5, a);
    wr_byte(8'h3C, 2, a);
    bus_stop;
    chk("R9 strobe despite glitch", wr_cnt - b0, 1);
    chk("R9 data intact", wd_log[b0 % 16], 16'h963C);
    chk("R9 address intact", wa_log[b0 % 16], 8'h05);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wq(5);
    t_reset;
    rst_n = 1'b1;
    wq(5);
    t_reset;
    t_write;
    t_partial;
    t_burst;
    t_read;
    t_mismatch;
    t_nostart;
    t_glitch;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all requirements: watchdog expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule